// File: doc/BRIEF.md
# Clock Source Failure Fallback Controller

This block supervises the clock source of a microcontroller. Software picks either an external crystal or clock input or the internal RC oscillator as the system clock. Software also controls whether the RC oscillator runs. The block watches the ready status reported by the external source. If that status drops while the external source is driving the system clock, the block takes over. It turns the RC oscillator on and moves the clock select back to the internal source. It withholds the system-clock-ready indication for a short settling time and latches a failure flag, which can raise an interrupt.

The analog oscillators and the glitch-free clock multiplexer sit outside this block. Here they appear only as a select output, an enable output and a ready input. The ready input arrives asynchronously, so it passes through a two-stage synchronizer before edge detection. Once the block has fallen back, it stays in that state. Recovery of the external source changes nothing on its own: software must write the select again, and that write is accepted only while the external source reports ready.

Top module: `oscfail_switch`

## Requirements
- R1: After reset, clkSelExt is 0, rcEnable is 1, sysClkRdy is 1, failFlag is 0 and failIrq is 0.
- R2: A failure is detected when clkSelExt is 1 and the synchronized external-ready changes from 1 to 0. The outputs react on the third rising clock edge after extRdyAsync falls: two edges for the synchronizer, one for the state update.
- R3: On a detected failure, rcEnable becomes 1 whatever software last wrote to the RC-enable bit, including a write of 0 in the same cycle.
- R4: On a detected failure, clkSelExt becomes 0, even if a select write occurs in the same cycle.
- R5: sysClkRdy is 0 for exactly DELAY_CYCLES (default 4) cycles after the edge that applies the failure, then returns to 1.
- R6: A detected failure sets failFlag to 1. failIrq equals failFlag AND intEn.
- R7: failFlag is cleared only by a flag write with data 0. A flag write with data 1 has no effect.
- R8: After a failure, clkSelExt stays 0 when the external-ready input recovers, until software writes the select.
- R9: During fallback, a select write is accepted only when the synchronized external-ready is 1. An accepted write ends fallback. Outside fallback, select writes are always accepted.
- R10: A falling edge of external-ready while clkSelExt is 0 changes no output and does not set failFlag.
- R11: A write to the RC-enable bit sets rcEnable to the written value when no failure occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running supervision clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extRdyAsync | input | 1 | Ready status of the external source, asynchronous |
| selWrEn | input | 1 | Software write strobe for the clock-select bit |
| selWrData | input | 1 | Written select value (1 = external source) |
| rceWrEn | input | 1 | Software write strobe for the RC-enable bit |
| rceWrData | input | 1 | Written RC-enable value |
| flagWrEn | input | 1 | Software write strobe for the failure flag |
| flagWrData | input | 1 | Written flag value (only 0 has an effect) |
| intEn | input | 1 | Failure interrupt enable |
| clkSelExt | output | 1 | Effective clock select (1 = external) |
| rcEnable | output | 1 | RC oscillator enable |
| sysClkRdy | output | 1 | System clock ready |
| failFlag | output | 1 | Latched failure flag |
| failIrq | output | 1 | Failure interrupt request |

## Verification
The assertions check the cycle that follows any detected failure on every clock: the select is cleared, the RC oscillator is enabled, the flag is set and ready is withdrawn. They also check on every clock that the flag and the fallback select do not change without the matching software write. Some behaviour can only be shown by the bench's scenarios: the three-edge latency from the asynchronous input, the exact length of the ready gap, rejection of a select write while the source is still down, and the lack of any reaction to an edge while the internal source is selected. The bench compares every output against its reference model on every clock in these scenarios.

// File: rtl/oscfail_pkg.sv
package oscfail_pkg;
  typedef struct packed {
    logic forceFail;   // failure detected this cycle
    logic selAccept;   // software select write accepted
    logic flagClear;   // software clear of the failure flag
  } ctlStrobes_t;
endpackage

// File: rtl/oscfail_ctrl.sv
module oscfail_ctrl
  import oscfail_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extRdyAsync,
  input  logic        selWrEn,
  input  logic        flagWrEn,
  input  logic        flagWrData,
  input  logic        selExt,
  input  logic        inFallback,
  output ctlStrobes_t strb
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic rdyPrev;
  logic rdySync;
  logic fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      rdyPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], extRdyAsync};
      rdyPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign rdySync  = syncChain[SYNC_STAGES-1];
  assign fallEdge = rdyPrev & ~rdySync;

  always_comb begin
    strb.forceFail = selExt & fallEdge;
    strb.selAccept = selWrEn & ~strb.forceFail & (~inFallback | rdySync);
    strb.flagClear = flagWrEn & ~flagWrData & ~strb.forceFail;
  end

  // R10: no failure strobe while the internal source is selected
  assert_no_fail_internal_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!selExt && fallEdge) |-> !strb.forceFail);
endmodule

// File: rtl/oscfail_dp.sv
module oscfail_dp
  import oscfail_pkg::*;
#(
  parameter int DELAY_CYCLES = 4,
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic        selWrData,
  input  logic        rceWrEn,
  input  logic        rceWrData,
  output logic        selExt,
  output logic        inFallback,
  output logic        rcEnable,
  output logic        sysClkRdy,
  output logic        failFlag
);
  localparam logic [CNT_W-1:0] DELAY_LOAD = CNT_W'(DELAY_CYCLES);

  logic [CNT_W-1:0] delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selExt     <= 1'b0;
      inFallback <= 1'b0;
      rcEnable   <= 1'b1;
      failFlag   <= 1'b0;
      delayCnt   <= '0;
    end else if (strb.forceFail) begin
      selExt     <= 1'b0;
      inFallback <= 1'b1;
      rcEnable   <= 1'b1;
      failFlag   <= 1'b1;
      delayCnt   <= DELAY_LOAD;
    end else begin
      if (strb.selAccept) begin
        selExt     <= selWrData;
        inFallback <= 1'b0;
      end
      if (rceWrEn) rcEnable <= rceWrData;
      if (strb.flagClear) failFlag <= 1'b0;
      if (delayCnt != '0) delayCnt <= delayCnt - 1'b1;
    end
  end

  assign sysClkRdy = (delayCnt == '0);

  assert_fail_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceFail |=> !selExt);
  assert_fail_rc_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceFail |=> rcEnable);
  assert_fail_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceFail |=> failFlag);
  assert_rdy_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceFail |=> !sysClkRdy);
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strb.flagClear) |=> failFlag);
  assert_fallback_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inFallback && !strb.selAccept) |=> !selExt);
endmodule

// File: rtl/oscfail_switch.sv
module oscfail_switch
  import oscfail_pkg::*;
#(
  parameter int DELAY_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extRdyAsync,
  input  logic selWrEn,
  input  logic selWrData,
  input  logic rceWrEn,
  input  logic rceWrData,
  input  logic flagWrEn,
  input  logic flagWrData,
  input  logic intEn,
  output logic clkSelExt,
  output logic rcEnable,
  output logic sysClkRdy,
  output logic failFlag,
  output logic failIrq
);
  ctlStrobes_t strb;
  logic inFallback;

  oscfail_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .extRdyAsync(extRdyAsync),
    .selWrEn(selWrEn), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .selExt(clkSelExt), .inFallback(inFallback), .strb(strb)
  );

  oscfail_dp #(.DELAY_CYCLES(DELAY_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .selWrData(selWrData),
    .rceWrEn(rceWrEn), .rceWrData(rceWrData),
    .selExt(clkSelExt), .inFallback(inFallback), .rcEnable(rcEnable),
    .sysClkRdy(sysClkRdy), .failFlag(failFlag)
  );

  assign failIrq = failFlag & intEn;
endmodule

// File: tb/oscfail_switch_tb.sv
module oscfail_switch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extRdyAsync = 1'b0;
  logic selWrEn = 1'b0, selWrData = 1'b0;
  logic rceWrEn = 1'b0, rceWrData = 1'b0;
  logic flagWrEn = 1'b0, flagWrData = 1'b0;
  logic intEn = 1'b0;
  logic clkSelExt, rcEnable, sysClkRdy, failFlag, failIrq;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;  // 125 MHz

  oscfail_switch dut_i (
    .clk(clk), .rstN(rstN), .extRdyAsync(extRdyAsync),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .rceWrEn(rceWrEn), .rceWrData(rceWrData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .intEn(intEn),
    .clkSelExt(clkSelExt), .rcEnable(rcEnable), .sysClkRdy(sysClkRdy),
    .failFlag(failFlag), .failIrq(failIrq)
  );

  // Behavioural reference model: a queue holds the synchronizer history
  bit rdyHist[$] = '{0, 0, 0};  // [0]=newest sample, [2]=previous synced value
  bit mSel = 0, mFb = 0, mRce = 1, mFlag = 0;
  int mGap = 0;

  always @(posedge clk) begin
    bit fail;
    bit synced;
    if (!rstN) begin
      rdyHist = '{0, 0, 0};
      mSel = 0; mFb = 0; mRce = 1; mFlag = 0; mGap = 0;
    end else begin
      synced = rdyHist[1];
      fail = mSel && rdyHist[2] && !synced;
      if (fail) begin
        mSel = 0; mFb = 1; mRce = 1; mFlag = 1; mGap = 4;
      end else begin
        if (selWrEn && (!mFb || synced)) begin mSel = selWrData; mFb = 0; end
        if (rceWrEn) mRce = rceWrData;
        if (flagWrEn && !flagWrData) mFlag = 0;
        if (mGap > 0) mGap--;
      end
      rdyHist.push_front(extRdyAsync);
      void'(rdyHist.pop_back());
    end
  end

  task automatic check(string what, string req, bit act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, midway between the posedge and the next negedge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check("clkSelExt", "R2/R4/R8/R9/R10", clkSelExt, mSel);
      check("rcEnable",  "R3/R11",          rcEnable,  mRce);
      check("sysClkRdy", "R5",              sysClkRdy, mGap == 0);
      check("failFlag",  "R6/R7",           failFlag,  mFlag);
      check("failIrq",   "R6",              failIrq,   mFlag & intEn);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrSel(bit v);
    @(negedge clk); selWrEn = 1; selWrData = v;
    @(negedge clk); selWrEn = 0;
  endtask

  task automatic wrRce(bit v);
    @(negedge clk); rceWrEn = 1; rceWrData = v;
    @(negedge clk); rceWrEn = 0;
  endtask

  task automatic wrFlag(bit v);
    @(negedge clk); flagWrEn = 1; flagWrData = v;
    @(negedge clk); flagWrEn = 0;
  endtask

  task automatic setRdy(bit v);
    @(negedge clk); extRdyAsync = v;
  endtask

  initial begin
    fork
      begin
        #20 rstN = 1;
        @(negedge clk);
        // R1: reset values
        check("clkSelExt", "R1", clkSelExt, 0);
        check("rcEnable",  "R1", rcEnable,  1);
        check("sysClkRdy", "R1", sysClkRdy, 1);
        check("failFlag",  "R1", failFlag,  0);
        check("failIrq",   "R1", failIrq,   0);

        // R10: edge while internal selected
        setRdy(1); idle(4); setRdy(0); idle(6);
        check("failFlag", "R10", failFlag, 0);

        // R2/R4/R3/R5/R6: failure on external source, RC disabled by software
        setRdy(1); idle(4);
        wrSel(1); wrRce(0); intEn = 1; idle(2);
        check("clkSelExt", "R9", clkSelExt, 1);
        check("rcEnable", "R11", rcEnable, 0);
        setRdy(0);
        idle(2);
        check("clkSelExt", "R2", clkSelExt, 1);  // only two edges so far
        idle(1);
        check("clkSelExt", "R4", clkSelExt, 0);
        check("rcEnable",  "R3", rcEnable,  1);
        check("sysClkRdy", "R5", sysClkRdy, 0);
        check("failIrq",   "R6", failIrq,   1);
        idle(3);
        check("sysClkRdy", "R5", sysClkRdy, 0);
        idle(1);
        check("sysClkRdy", "R5", sysClkRdy, 1);

        // R9: select write while still down is rejected
        wrSel(1);
        check("clkSelExt", "R9", clkSelExt, 0);
        // R8: recovery alone does not reselect
        setRdy(1); idle(6);
        check("clkSelExt", "R8", clkSelExt, 0);
        // R7: writing 1 to flag does nothing, writing 0 clears
        wrFlag(1);
        check("failFlag", "R7", failFlag, 1);
        intEn = 0; idle(1);
        check("failIrq", "R6", failIrq, 0);
        wrFlag(0);
        check("failFlag", "R7", failFlag, 0);
        // R9: accepted once ready
        wrSel(1);
        check("clkSelExt", "R9", clkSelExt, 1);

        // Short one-cycle dropout with concurrent writes in failure cycle
        @(negedge clk); extRdyAsync = 0;
        @(negedge clk); extRdyAsync = 1;
        @(negedge clk); selWrEn = 1; selWrData = 1; rceWrEn = 1; rceWrData = 0;
        @(negedge clk); selWrEn = 0; rceWrEn = 0;
        idle(2);
        check("clkSelExt", "R4", clkSelExt, 0);
        check("rcEnable",  "R3", rcEnable,  1);
        idle(8);
      end
      begin
        #100000;
        mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule